// File: doc/BRIEF.md
# SPI Slave Host Buffer Interface

This block is the device side of a serial link that a host drives as an SPI slave in mode 0. Bytes sent by the host fill an input buffer. In the same transfer, the block shifts out bytes from an output buffer that the local core loads in advance. Each buffer holds 128 bytes.

The local core sees a small byte-wide register space. It holds two input-level threshold settings, a sticky event status register and an event enable register. It also holds byte-addressed windows onto both buffers. Two independent thresholds report how far the host has written. One is typically set to half the buffer. The other is typically set to the length of a command header.

Chip-select edges are reported as events in both directions. This does not depend on serial clock activity, so a chip-select glitch with no clocks is still visible. A single interrupt output combines the enabled events.

The serial pins are asynchronous to the system clock and are synchronised on entry. The register port is a plain single-cycle bus: writes take effect at the next clock edge and reads are combinational. The block never stalls the host and has no back-pressure. The core must load the output buffer before the host clocks it out.

Top module: `shb_host_if`

## Requirements
- R1: After reset the registers read as follows: level-1 config (address 0x000) reads 0x40, level-2 config (0x001) reads 0x08, status (0x002) reads 0x00 and enable (0x003) reads 0x00. The irq output is 0.
- R2: With chip select low, the block samples spi_mosi on each rising spi_sck edge, MSB first. Each completed byte k of a transfer is readable at input window address 0x180+k.
- R3: Bytes written by the core to output window address 0x100+k are readable there. During a transfer, byte k is driven on spi_miso MSB first, with each bit valid before the rising edge that samples it.
- R4: The byte pointer and the bit position are reset on every chip-select falling edge. Each transfer therefore starts at buffer entry 0.
- R5: Level-1 config holds the threshold in bits 6:0 and a disable in bit 7. When enabled, status bit 3 sets when the byte count of the transfer becomes equal to the threshold, modulo 128. A threshold of 0 fires after 128 bytes.
- R6: Level-2 config holds a 6-bit threshold in bits 5:0 and a disable in bit 7. When enabled, status bit 0 sets when the byte count becomes equal to the threshold.
- R7: A level event fires only at the byte where the count becomes equal to its threshold. Once cleared, it does not set again while further bytes arrive beyond that threshold.
- R8: Status bit 1 sets when chip select rises and status bit 2 sets when chip select falls. Both set even if spi_sck never toggled.
- R9: Status bits are sticky. Writing status with a 1 in a bit position clears that bit only; bits written with 0 are kept.
- R10: Enable bits use the same positions as status. irq is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host (mode 0) |
| spi_csn | input | 1 | Active-low chip select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (0 while deselected) |
| reg_addr | input | 9 | Register/window address: 0x000-0x003 registers, 0x100-0x17F output buffer, 0x180-0x1FF input buffer |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr (0 for unmapped) |
| irq | output | 1 | Interrupt: OR of enabled status bits |

## Verification
Full-duplex transfers run with several arithmetic byte patterns in both directions. Each pattern has a distinct value per byte position, so a slipped bit, a swapped byte or a stale pointer from the previous transfer shows up as a mismatch.

Each level threshold is swept across small, mid-range, top-of-range and wrap-to-zero values while the other threshold is disabled. The status is read after every byte, which tells an early or late trigger from a correct one, and keeps the two thresholds apart. A clockless chip-select pulse and a clear issued mid-transfer separate edge detection and one-shot level behaviour from plain level sensing.

// File: rtl/shb_pkg.sv
package shb_pkg;
  // status / enable bit positions (decoded by software)
  localparam int EV_LVL2 = 0;
  localparam int EV_CSR  = 1;
  localparam int EV_CSF  = 2;
  localparam int EV_LVL1 = 3;
  localparam int EV_W    = 4;
  localparam int LVL2_W  = 6;
  // register offsets
  localparam logic [1:0] RA_LVL1 = 2'd0;
  localparam logic [1:0] RA_LVL2 = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_EN   = 2'd3;
endpackage

// File: rtl/shb_sync.sv
module shb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/shb_shift.sv
module shb_shift #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             csn_s,
  input  logic             mosi_s,
  output logic             cs_active,
  output logic             cs_rise_evt,
  output logic             cs_fall_evt,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [PTR_W-1:0] ptr,
  output logic [2:0]       bit_idx
);
  logic       csn_q, sck_q;
  logic [6:0] shreg;
  logic       sck_rise;

  assign cs_active   = ~csn_s;
  assign cs_rise_evt = ~csn_q & csn_s;   // deassertion
  assign cs_fall_evt = csn_q & ~csn_s;   // assertion
  assign sck_rise    = sck_s & ~sck_q & cs_active & ~cs_fall_evt;
  assign byte_done   = sck_rise && (bit_idx == 3'd7);
  assign rx_byte     = {shreg, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q   <= 1'b1;
      sck_q   <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      ptr     <= '0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
      if (cs_fall_evt) begin
        bit_idx <= '0;
        ptr     <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_s};
        bit_idx <= bit_idx + 3'd1;
        if (byte_done) ptr <= ptr + 1'b1;
      end
    end
  end

  // R4: a new transfer starts at entry 0, bit 0
  p_fall_resets_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_evt |=> (ptr == '0 && bit_idx == 3'd0));
  // R2: each completed byte advances the pointer by one
  p_byte_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/shb_events.sv
module shb_events
  import shb_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              cs_rise_evt,
  input  logic              cs_fall_evt,
  input  logic [PTR_W-1:0]  lvl1_lvl,
  input  logic              lvl1_dis,
  input  logic [LVL2_W-1:0] lvl2_lvl,
  input  logic              lvl2_dis,
  input  logic [EV_W-1:0]   enable,
  input  logic              clr_wr,
  input  logic [EV_W-1:0]   clr_mask,
  output logic [EV_W-1:0]   status,
  output logic              irq
);
  logic [PTR_W-1:0] ptr_nxt;
  logic [EV_W-1:0]  set_v, clr_v;

  assign ptr_nxt = ptr + 1'b1;
  assign clr_v   = clr_wr ? clr_mask : '0;

  always_comb begin
    set_v          = '0;
    set_v[EV_LVL1] = byte_done && !lvl1_dis && (ptr_nxt == lvl1_lvl);
    set_v[EV_LVL2] = byte_done && !lvl2_dis && (ptr_nxt == PTR_W'(lvl2_lvl));
    set_v[EV_CSR]  = cs_rise_evt;
    set_v[EV_CSF]  = cs_fall_evt;
  end

  // new events win over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_v) | set_v;
  end

  assign irq = |(status & enable);

  // R8: chip-select deassertion always flags, clocks or not
  p_cs_rise_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> status[EV_CSR]);
  // R6: a disabled level-2 compare never raises its flag
  p_lvl2_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl2_dis && !status[EV_LVL2]) |=> !status[EV_LVL2]);
  // R9: a set flag stays until a 1 is written to it
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[EV_CSF] && !(clr_wr && clr_mask[EV_CSF])) |=> status[EV_CSF]);
endmodule

// File: rtl/shb_host_if.sv
module shb_host_if
  import shb_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic [7:0] obuf [DEPTH];
  logic [7:0] ibuf [DEPTH];

  logic              sck_s, csn_s, mosi_s;
  logic              cs_active, cs_rise_evt, cs_fall_evt, byte_done;
  logic [7:0]        rx_byte;
  logic [PTR_W-1:0]  ptr;
  logic [2:0]        bit_idx;
  logic [PTR_W-1:0]  lvl1_lvl;
  logic              lvl1_dis;
  logic [LVL2_W-1:0] lvl2_lvl;
  logic              lvl2_dis;
  logic [EV_W-1:0]   enable, status;
  logic              reg_sel, win_sel, stat_wr;
  logic [PTR_W-1:0]  win_idx;

  shb_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_csn, spi_mosi}),
    .q({sck_s, csn_s, mosi_s})
  );

  shb_shift #(.PTR_W(PTR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .cs_active(cs_active), .cs_rise_evt(cs_rise_evt), .cs_fall_evt(cs_fall_evt),
    .byte_done(byte_done), .rx_byte(rx_byte), .ptr(ptr), .bit_idx(bit_idx)
  );

  assign win_sel = reg_addr[ADDR_W-1];
  assign win_idx = reg_addr[PTR_W-1:0];
  assign reg_sel = !win_sel && (reg_addr[ADDR_W-2:2] == '0);
  assign stat_wr = reg_wr && reg_sel && (reg_addr[1:0] == RA_STAT);

  shb_events #(.PTR_W(PTR_W)) u_events (
    .clk(clk), .rst_n(rst_n),
    .byte_done(byte_done), .ptr(ptr),
    .cs_rise_evt(cs_rise_evt), .cs_fall_evt(cs_fall_evt),
    .lvl1_lvl(lvl1_lvl), .lvl1_dis(lvl1_dis),
    .lvl2_lvl(lvl2_lvl), .lvl2_dis(lvl2_dis),
    .enable(enable), .clr_wr(stat_wr), .clr_mask(reg_wdata[EV_W-1:0]),
    .status(status), .irq(irq)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl1_lvl <= PTR_W'(DEPTH / 2);
      lvl1_dis <= 1'b0;
      lvl2_lvl <= LVL2_W'(8);
      lvl2_dis <= 1'b0;
      enable   <= '0;
    end else if (reg_wr && reg_sel) begin
      case (reg_addr[1:0])
        RA_LVL1: begin
          lvl1_lvl <= reg_wdata[PTR_W-1:0];
          lvl1_dis <= reg_wdata[7];
        end
        RA_LVL2: begin
          lvl2_lvl <= reg_wdata[LVL2_W-1:0];
          lvl2_dis <= reg_wdata[7];
        end
        RA_EN:   enable <= reg_wdata[EV_W-1:0];
        default: ;
      endcase
    end
  end

  // buffers: core writes the output side, the serial side writes the input side
  always_ff @(posedge clk) begin
    if (reg_wr && win_sel && !reg_addr[PTR_W]) obuf[win_idx] <= reg_wdata;
    if (byte_done) ibuf[ptr] <= rx_byte;
  end

  assign spi_miso = cs_active ? obuf[ptr][3'd7 - bit_idx] : 1'b0;

  always_comb begin
    reg_rdata = '0;
    if (win_sel) begin
      reg_rdata = reg_addr[PTR_W] ? ibuf[win_idx] : obuf[win_idx];
    end else if (reg_sel) begin
      case (reg_addr[1:0])
        RA_LVL1: reg_rdata = {lvl1_dis, 7'(lvl1_lvl)};
        RA_LVL2: reg_rdata = {lvl2_dis, 1'b0, lvl2_lvl};
        RA_STAT: reg_rdata = 8'(status);
        default: reg_rdata = 8'(enable);
      endcase
    end
  end
endmodule

// File: tb/shb_host_if_tb.sv
module shb_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [8:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shb_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic cs_lo();
    @(posedge clk); #1 spi_csn = 1'b0;
    repeat (8) @(posedge clk); #1;
  endtask

  task automatic cs_hi();
    repeat (2) @(posedge clk); #1 spi_csn = 1'b1;
    repeat (8) @(posedge clk); #1;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      repeat (4) @(posedge clk); #1;
      spi_sck = 1'b1; rx[b] = spi_miso;
      repeat (4) @(posedge clk); #1;
      spi_sck = 1'b0;
    end
    repeat (4) @(posedge clk); #1;
  endtask

  function automatic logic [7:0] fo(int i, int p);
    return 8'((i * 37 + p * 91 + 5) & 255);
  endfunction
  function automatic logic [7:0] fi(int i, int p);
    return 8'(((i * 53 + p * 29 + 200) & 255) ^ 8'hA5);
  endfunction

  // sweep one level threshold; which=1 selects level 1 (bit 3), else level 2 (bit 0)
  task automatic lvl_sweep(input bit which, input int thr, input int nb, input bit dis);
    logic [7:0] rx, s;
    int exp;
    if (which) begin wr(9'h000, {dis, 7'(thr)}); wr(9'h001, 8'h80); end
    else       begin wr(9'h000, 8'h80); wr(9'h001, {dis, 1'b0, 6'(thr)}); end
    wr(9'h002, 8'h0F);
    cs_lo();
    for (int c = 1; c <= nb; c++) begin
      xfer(8'(c), rx);
      rd(9'h002, s);
      exp = dis ? 0 : ((thr == 0) ? int'(c >= 128) : int'(c >= thr));
      if (which) chk($sformatf("R5 lvl1 thr=%0d byte=%0d", thr, c), s[3], exp);
      else       chk($sformatf("R6 lvl2 thr=%0d byte=%0d", thr, c), s[0], exp);
      if (which) chk("R5 lvl2 quiet while disabled", s[0], 0);
      else       chk("R6 lvl1 quiet while disabled", s[3], 0);
    end
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, rx;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R1 reset values
    rd(9'h000, d); chk("R1 lvl1 cfg", d, 8'h40);
    rd(9'h001, d); chk("R1 lvl2 cfg", d, 8'h08);
    rd(9'h002, d); chk("R1 status", d, 8'h00);
    rd(9'h003, d); chk("R1 enable", d, 8'h00);
    chk("R1 irq", irq, 0);

    // R2/R3/R4: full-duplex patterns, pointer restarts each transfer
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 12; i++) wr(9'h100 + 9'(i), fo(i, p));
      for (int i = 0; i < 12; i++) begin
        rd(9'h100 + 9'(i), d); chk("R3 obuf readback", d, fo(i, p));
      end
      wr(9'h002, 8'h0F);
      cs_lo();
      for (int i = 0; i < 12; i++) begin
        xfer(fi(i, p), rx);
        chk($sformatf("R3 miso pat=%0d byte=%0d", p, i), rx, fo(i, p));
        if (i == 6 || i == 7) begin
          rd(9'h002, d); chk("R6 default lvl2 edge", d[0], int'(i == 7));
        end
      end
      cs_hi();
      for (int i = 0; i < 12; i++) begin
        rd(9'h180 + 9'(i), d);
        chk($sformatf("R2 R4 ibuf pat=%0d byte=%0d", p, i), d, fi(i, p));
      end
    end

    // R5 / R6 threshold sweeps
    lvl_sweep(1'b1, 3, 6, 1'b0);
    lvl_sweep(1'b1, 64, 66, 1'b0);
    lvl_sweep(1'b1, 127, 128, 1'b0);
    lvl_sweep(1'b1, 0, 129, 1'b0);
    lvl_sweep(1'b1, 3, 8, 1'b1);
    lvl_sweep(1'b0, 1, 3, 1'b0);
    lvl_sweep(1'b0, 8, 10, 1'b0);
    lvl_sweep(1'b0, 63, 65, 1'b0);
    lvl_sweep(1'b0, 8, 10, 1'b1);

    // R7 one-shot, R9 selective clear
    wr(9'h000, 8'h80); wr(9'h001, 8'h08); wr(9'h002, 8'h0F);
    cs_lo();
    for (int i = 0; i < 8; i++) xfer(8'(i), rx);
    rd(9'h002, d); chk("R6 lvl2 at 8", d[0], 1);
    wr(9'h002, 8'h01);
    rd(9'h002, d); chk("R9 cleared bit0", d[0], 0);
    chk("R9 bit2 kept", d[2], 1);
    for (int i = 0; i < 20; i++) xfer(8'(i), rx);
    rd(9'h002, d); chk("R7 no refire past level", d[0], 0);
    cs_hi();

    // R8 clockless chip-select glitch, R10 masking
    wr(9'h002, 8'h0F);
    rd(9'h002, d); chk("R9 all cleared", d, 8'h00);
    cs_lo(); cs_hi();
    rd(9'h002, d); chk("R8 glitch flags", d, 8'h06);
    chk("R10 irq masked off", irq, 0);
    wr(9'h003, 8'h02);
    chk("R10 irq on rise enable", irq, 1);
    wr(9'h002, 8'h02);
    chk("R10 irq after clear", irq, 0);
    rd(9'h002, d); chk("R9 fall flag kept", d, 8'h04);
    wr(9'h003, 8'h04);
    chk("R10 irq on fall enable", irq, 1);
    wr(9'h003, 8'h0B);
    chk("R10 irq other enables", irq, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule